// File: doc/BRIEF.md
# Sleep and Wake Mode Controller

This block decides when a small microcontroller core sleeps and when it wakes. Software writes two mode bits. One bit asks for a light sleep: the CPU clock stops but the peripherals keep running. The other bit asks for a deep sleep: the oscillator stops and every internal clock stops with it. The block turns these requests into a CPU clock enable, a peripheral clock enable and an oscillator run enable. Each clock enable is qualified by a tick from a divide-by-two flip-flop on the incoming clock.

The two sleep modes end in different ways. Any enabled interrupt ends light sleep, and a wake pulse goes to the interrupt logic. Deep sleep ends only when an enabled external interrupt pin goes low. The oscillator then restarts while the pin is held low. The wake pulse, and the return to execution, wait until that pin has gone high again.

A hardware reset ends either mode. When it ends light sleep, the core runs on for a short window before the reset takes effect, and writes to internal RAM are blocked during that window. The mode bits clear on every exit.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: While the oscillator runs, `tick_o` changes value on every input clock, and `cpu_clk_en_o` and `per_clk_en_o` are high only in cycles where `tick_o` is high.
- R2: After `rst_ni` is released, the block is in the running state: mode bits 00, oscillator on, CPU and peripheral clocks gated only by the tick, RAM writes allowed, `core_rst_o` and `wake_o` low.
- R3: A mode write with bit 0 set and bit 1 clear enters light sleep on the next cycle: the CPU clock enable stays low while the peripheral clock and oscillator keep running.
- R4: A mode write with bit 1 set enters deep sleep on the next cycle, whatever bit 0 holds. All three enables go low and `mode_o` holds the written value until the exit.
- R5: In light sleep, `irq_pend_i` high returns the block to running on the next cycle, with a `wake_o` pulse of exactly one cycle and the mode bits cleared.
- R6: In deep sleep, `irq_pend_i`, low pins whose enable is clear, and enabled pins that are high have no effect: the oscillator stays off.
- R7: In deep sleep, an enabled external pin going low turns the oscillator on the next cycle while the CPU stays stopped and no wake is signalled. When that pin is high again, the next cycle returns to running with a one-cycle `wake_o` pulse and the mode bits cleared.
- R8: `hw_reset_i` during deep sleep, or while the oscillator is restarting, returns the block to running on the next cycle with the mode bits cleared and no `wake_o` pulse.
- R9: `hw_reset_i` during light sleep reopens the CPU clock and raises `ram_wr_block_o` with `core_rst_o` low for exactly GUARD_MC×TICKS_PER_MC ticks. After that window, `ram_wr_block_o` falls, the mode bits read 00 and `core_rst_o` follows `hw_reset_i`.
- R10: While running, `core_rst_o` follows `hw_reset_i` in the same cycle, and mode writes made while `hw_reset_i` is high are ignored; the mode bits stay 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Incoming oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| hw_reset_i | input | 1 | Hardware reset pin, active high |
| mode_wr_i | input | 1 | Write strobe for the mode bits |
| mode_wdata_i | input | 2 | Mode bits written: bit 0 light sleep, bit 1 deep sleep |
| mode_o | output | 2 | Current mode bits |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| ext_pin_n_i | input | NUM_EXT | External interrupt pins, active low |
| ext_en_i | input | NUM_EXT | Enable for each external interrupt |
| tick_o | output | 1 | Divided internal clock phase |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_run_o | output | 1 | Oscillator run enable |
| ram_wr_block_o | output | 1 | Block writes to internal RAM |
| core_rst_o | output | 1 | Reset applied to the core |
| wake_o | output | 1 | One-cycle wake indication to the interrupt logic |

## Verification
The bench builds the block with NUM_EXT=2, DIV2=1, TICKS_PER_MC=3 and GUARD_MC=2. This gives a six-tick protection window, so the exact length of the reset-exit window is measured tick by tick in a few dozen clocks. Two external pins allow a low pin whose enable is clear to be tried next to an enabled pin. The divider variant makes the alternating tick observable, so every cycle also checks the clock qualification.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_IDLE  = 3'd1,
      ST_PD    = 3'd2,
      ST_WAKE  = 3'd3,
      ST_GUARD = 3'd4
   } pmc_state_e;

   localparam int MB_IDLE = 0;
   localparam int MB_PD   = 1;
   localparam int MODE_W  = 2;
endpackage

// File: rtl/pmc_clkdiv.sv
module pmc_clkdiv #(
   parameter bit DIV2 = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (DIV2) begin : g_div2
         logic ph_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)    ph_q <= 1'b0;
            else if (run_i) ph_q <= ~ph_q;
         end
         assign tick_o = ph_q;

         // R1: the phase flips on every clock while the oscillator runs
         a_r1_tick_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
            run_i |=> (tick_o != $past(tick_o)));
      end else begin : g_pass
         assign tick_o = run_i;
      end
   endgenerate
endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
   parameter int NUM_EXT = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               arm_i,
   input  logic [NUM_EXT-1:0] pin_n_i,
   input  logic [NUM_EXT-1:0] en_i,
   output logic               wake_req_o,
   output logic               release_o
);
   logic [NUM_EXT-1:0] low_en;
   logic [NUM_EXT-1:0] hold_q;

   assign low_en     = en_i & ~pin_n_i;
   assign wake_req_o = |low_en;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  hold_q <= '0;
      else if (arm_i && wake_req_o) hold_q <= low_en;
   end

   assign release_o = ~|(hold_q & ~pin_n_i);

   // R7: a qualified wake always records at least one pin to wait on
   a_r7_hold_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && wake_req_o) |=> (hold_q != '0));
endmodule

// File: rtl/pmc_guard.sv
module pmc_guard #(
   parameter int LEN = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic active_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(LEN - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (!active_i) cnt_q <= '0;
      else if (tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assign done_o = active_i & tick_i & (cnt_q == LAST);

   // R9: the window count is restarted whenever the window is closed
   a_r9_cnt_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i |=> (cnt_q == '0));
   // R9: the count never passes the last tick of the window
   a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_i |=> (cnt_q <= LAST));
endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int NUM_EXT      = 2,
   parameter bit DIV2         = 1'b1,
   parameter int TICKS_PER_MC = 6,
   parameter int GUARD_MC     = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               hw_reset_i,
   input  logic               mode_wr_i,
   input  logic [MODE_W-1:0]  mode_wdata_i,
   output logic [MODE_W-1:0]  mode_o,
   input  logic               irq_pend_i,
   input  logic [NUM_EXT-1:0] ext_pin_n_i,
   input  logic [NUM_EXT-1:0] ext_en_i,
   output logic               tick_o,
   output logic               cpu_clk_en_o,
   output logic               per_clk_en_o,
   output logic               osc_run_o,
   output logic               ram_wr_block_o,
   output logic               core_rst_o,
   output logic               wake_o
);
   localparam int GUARD_TICKS = TICKS_PER_MC * GUARD_MC;

   generate
      if (NUM_EXT < 1 || NUM_EXT > 8) begin : g_bad_ext
         $error("pmc_mode_ctrl: NUM_EXT must lie in 1..8");
      end
      if (GUARD_TICKS < 1) begin : g_bad_guard
         $error("pmc_mode_ctrl: protection window must be at least one tick");
      end
   endgenerate

   pmc_state_e        st_q, st_n;
   logic [MODE_W-1:0] mode_q, mode_n;
   logic              wake_q, wake_n;
   logic              tick, wake_req, wake_rel, guard_done;
   logic              cpu_on, per_on;

   pmc_clkdiv #(.DIV2(DIV2)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (osc_run_o),
      .tick_o (tick)
   );

   pmc_wake_qual #(.NUM_EXT(NUM_EXT)) u_wake (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .arm_i      (st_q == ST_PD),
      .pin_n_i    (ext_pin_n_i),
      .en_i       (ext_en_i),
      .wake_req_o (wake_req),
      .release_o  (wake_rel)
   );

   pmc_guard #(.LEN(GUARD_TICKS)) u_guard (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (st_q == ST_GUARD),
      .tick_i   (tick),
      .done_o   (guard_done)
   );

   always_comb begin
      st_n   = st_q;
      mode_n = mode_q;
      wake_n = 1'b0;
      unique case (st_q)
         ST_RUN: begin
            if (hw_reset_i) begin
               mode_n = '0;
            end else if (mode_wr_i) begin
               mode_n = mode_wdata_i;
               if (mode_wdata_i[MB_PD])        st_n = ST_PD;
               else if (mode_wdata_i[MB_IDLE]) st_n = ST_IDLE;
            end
         end
         ST_IDLE: begin
            if (hw_reset_i) begin
               st_n = ST_GUARD;
            end else if (irq_pend_i) begin
               st_n   = ST_RUN;
               mode_n = '0;
               wake_n = 1'b1;
            end
         end
         ST_PD: begin
            if (hw_reset_i) begin
               st_n   = ST_RUN;
               mode_n = '0;
            end else if (wake_req) begin
               st_n = ST_WAKE;
            end
         end
         ST_WAKE: begin
            if (hw_reset_i) begin
               st_n   = ST_RUN;
               mode_n = '0;
            end else if (wake_rel) begin
               st_n   = ST_RUN;
               mode_n = '0;
               wake_n = 1'b1;
            end
         end
         ST_GUARD: begin
            if (guard_done) begin
               st_n   = ST_RUN;
               mode_n = '0;
            end
         end
         default: begin
            st_n   = ST_RUN;
            mode_n = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_RUN;
         mode_q <= '0;
         wake_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         mode_q <= mode_n;
         wake_q <= wake_n;
      end
   end

   assign cpu_on         = (st_q == ST_RUN) || (st_q == ST_GUARD);
   assign per_on         = cpu_on || (st_q == ST_IDLE);
   assign osc_run_o      = (st_q != ST_PD);
   assign cpu_clk_en_o   = cpu_on & tick;
   assign per_clk_en_o   = per_on & tick;
   assign ram_wr_block_o = (st_q == ST_GUARD);
   assign core_rst_o     = (st_q == ST_RUN) & hw_reset_i;
   assign tick_o         = tick;
   assign mode_o         = mode_q;
   assign wake_o         = wake_q;

   // R4: a write with the deep-sleep bit wins over the light-sleep bit
   a_r4_pd_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN && !hw_reset_i && mode_wr_i && mode_wdata_i[MB_PD])
      |=> (st_q == ST_PD));
   // R5: the wake indication lasts a single cycle
   a_r5_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |=> !wake_o);
   // R6: deep sleep persists without reset or a qualified pin
   a_r6_pd_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_PD && !hw_reset_i && !wake_req) |=> (st_q == ST_PD));
   // R7: the held pin rising releases the core with a wake pulse
   a_r7_release_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_WAKE && !hw_reset_i && wake_rel) |=> wake_o);
   // R8: a reset outside light sleep clears the mode bits
   a_r8_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_reset_i && st_q != ST_IDLE && st_q != ST_GUARD) |=> (mode_q == '0));
   // R9: a reset taken in light sleep opens the protection window
   a_r9_guard_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && hw_reset_i) |=> (ram_wr_block_o && !core_rst_o));
endmodule

// File: tb/pmc_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pmc_mode_ctrl_tb_top;
   typedef struct {
      int         req;
      logic [7:0] care;
      logic [7:0] val;
   } item_t;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       hw_reset_i = 1'b0;
   logic       mode_wr_i = 1'b0;
   logic [1:0] mode_wdata_i = 2'b00;
   logic       irq_pend_i = 1'b0;
   logic [1:0] ext_pin_n_i = 2'b11;
   logic [1:0] ext_en_i = 2'b00;
   logic [1:0] mode_o;
   logic       tick_o, cpu_clk_en_o, per_clk_en_o, osc_run_o;
   logic       ram_wr_block_o, core_rst_o, wake_o;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    g_ticks = 0;
   logic  prev_osc = 1'b0;
   logic  prev_tick = 1'b0;
   bit    done = 1'b0;

   always #2 clk_i = ~clk_i;

   pmc_mode_ctrl #(
      .NUM_EXT(2), .DIV2(1'b1), .TICKS_PER_MC(3), .GUARD_MC(2)
   ) dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .hw_reset_i(hw_reset_i),
      .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i), .mode_o(mode_o),
      .irq_pend_i(irq_pend_i), .ext_pin_n_i(ext_pin_n_i), .ext_en_i(ext_en_i),
      .tick_o(tick_o), .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
      .osc_run_o(osc_run_o), .ram_wr_block_o(ram_wr_block_o),
      .core_rst_o(core_rst_o), .wake_o(wake_o)
   );

   // vector layout: mode[1:0], cpu, per, osc, ram block, core reset, wake
   function automatic logic [7:0] ex(input logic [1:0] m, input logic cpu, per,
                                     osc, blk, rst, wk);
      return {m, cpu, per, osc, blk, rst, wk};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic cyc(input logic hr, wr, input logic [1:0] wd, input logic irq,
                      input logic [1:0] pn, en, input int req,
                      input logic [7:0] care, val);
      item_t it;
      @(negedge clk_i);
      hw_reset_i = hr; mode_wr_i = wr; mode_wdata_i = wd;
      irq_pend_i = irq; ext_pin_n_i = pn; ext_en_i = en;
      it.req = req; it.care = care; it.val = val;
      sb_q.push_back(it);
   endtask

   // monitor: samples after each edge, checks R1 and pops the scoreboard
   always @(posedge clk_i) begin
      item_t      it;
      logic [7:0] obs, care;
      #1;
      obs = {mode_o, cpu_clk_en_o, per_clk_en_o, osc_run_o,
             ram_wr_block_o, core_rst_o, wake_o};
      if (rst_ni) begin
         if (osc_run_o && prev_osc) begin
            n_chk++;
            if (tick_o == prev_tick) begin
               n_fail++;
               $display("FAIL R1 tick: actual=%b expected=%b", tick_o, !prev_tick);
            end
         end
         if (!tick_o) begin
            n_chk++;
            if (cpu_clk_en_o || per_clk_en_o) begin
               n_fail++;
               $display("FAIL R1 enables off-tick: actual=%b%b expected=00",
                        cpu_clk_en_o, per_clk_en_o);
            end
         end
         if (ram_wr_block_o && cpu_clk_en_o) g_ticks++;
      end
      prev_osc  = osc_run_o && rst_ni;
      prev_tick = tick_o;
      if (sb_q.size() > 0) begin
         it   = sb_q.pop_front();
         care = it.care;
         if (!tick_o) care[5:4] = 2'b00;
         if (care != 8'h00) begin
            n_chk++;
            if ((obs & care) !== (it.val & care)) begin
               n_fail++;
               $display("FAIL R%0d: actual=%b expected=%b (care %b)",
                        it.req, obs & care, it.val & care, care);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] run_v;
      run_v = ex(2'b00, 1, 1, 1, 0, 0, 0);
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;

      // R2: state after reset, both tick phases
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 2, 8'hFF, run_v);
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 2, 8'hFF, run_v);

      // R3: light sleep entry
      cyc(0, 1, 2'b01, 0, 2'b11, 2'b00, 3, 8'hFF, ex(2'b01, 0, 1, 1, 0, 0, 0));
      for (int k = 0; k < 3; k++)
         cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 3, 8'hFF, ex(2'b01, 0, 1, 1, 0, 0, 0));
      // R5: enabled interrupt ends light sleep with a one-cycle wake
      cyc(0, 0, 2'b00, 1, 2'b11, 2'b00, 5, 8'hFF, ex(2'b00, 1, 1, 1, 0, 0, 1));
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 5, 8'hFF, run_v);

      // R4: both bits written, deep sleep wins
      cyc(0, 1, 2'b11, 0, 2'b11, 2'b00, 4, 8'hFF, ex(2'b11, 0, 0, 0, 0, 0, 0));
      // R6: pending interrupt, disabled low pin, enabled high pins
      cyc(0, 0, 2'b00, 1, 2'b11, 2'b00, 6, 8'hFF, ex(2'b11, 0, 0, 0, 0, 0, 0));
      cyc(0, 0, 2'b00, 0, 2'b10, 2'b00, 6, 8'hFF, ex(2'b11, 0, 0, 0, 0, 0, 0));
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b11, 6, 8'hFF, ex(2'b11, 0, 0, 0, 0, 0, 0));
      // R7: enabled pin 1 low restarts the oscillator, no wake yet
      cyc(0, 0, 2'b00, 0, 2'b01, 2'b10, 7, 8'hFF, ex(2'b11, 0, 0, 1, 0, 0, 0));
      cyc(0, 0, 2'b00, 0, 2'b01, 2'b10, 7, 8'hFF, ex(2'b11, 0, 0, 1, 0, 0, 0));
      cyc(0, 0, 2'b00, 0, 2'b01, 2'b10, 7, 8'hFF, ex(2'b11, 0, 0, 1, 0, 0, 0));
      // R7: the pin rising releases the core
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b10, 7, 8'hFF, ex(2'b00, 1, 1, 1, 0, 0, 1));
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 7, 8'hFF, run_v);

      // R4: deep-sleep bit alone, then R8 reset exit from deep sleep
      cyc(0, 1, 2'b10, 0, 2'b11, 2'b00, 4, 8'hFF, ex(2'b10, 0, 0, 0, 0, 0, 0));
      cyc(1, 0, 2'b00, 0, 2'b11, 2'b00, 8, 8'hFF, ex(2'b00, 1, 1, 1, 0, 1, 0));
      // R10: a write while reset is held is ignored
      cyc(1, 1, 2'b01, 0, 2'b11, 2'b00, 10, 8'hFF, ex(2'b00, 1, 1, 1, 0, 1, 0));
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 10, 8'hFF, run_v);

      // R8: reset while the oscillator restarts
      cyc(0, 1, 2'b10, 0, 2'b11, 2'b00, 8, 8'hFF, ex(2'b10, 0, 0, 0, 0, 0, 0));
      cyc(0, 0, 2'b00, 0, 2'b10, 2'b01, 8, 8'hFF, ex(2'b10, 0, 0, 1, 0, 0, 0));
      cyc(1, 0, 2'b00, 0, 2'b10, 2'b01, 8, 8'hFF, ex(2'b00, 1, 1, 1, 0, 1, 0));
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 8, 8'hFF, run_v);

      // R9: reset in light sleep opens the protection window
      cyc(0, 1, 2'b01, 0, 2'b11, 2'b00, 3, 8'hFF, ex(2'b01, 0, 1, 1, 0, 0, 0));
      g_ticks = 0;
      cyc(1, 0, 2'b00, 0, 2'b11, 2'b00, 9, 8'hFF, ex(2'b01, 1, 1, 1, 1, 0, 0));
      for (int k = 0; k < 40; k++) begin
         cyc(1, 0, 2'b00, 0, 2'b11, 2'b00, 9, 8'h00, 8'h00);
         @(posedge clk_i);
         #2;
         if (!ram_wr_block_o) break;
      end
      chk("R9 window ticks", 32'(g_ticks), 32'd6);
      chk("R9 block released", 32'(ram_wr_block_o), 32'd0);
      chk("R9 reset takes over", 32'(core_rst_o), 32'd1);
      chk("R9 mode cleared", 32'(mode_o), 32'd0);
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 9, 8'hFF, run_v);
      cyc(0, 0, 2'b00, 0, 2'b11, 2'b00, 2, 8'hFF, run_v);

      @(posedge clk_i);
      #3;
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule